// File: doc/BRIEF.md
# Parity-protected SRAM bank wrapper

This block sits between a simple 32-bit bus slave port and one synchronous single-port SRAM bank of 2048 words (8 KiB). Every byte lane of a stored word carries its own even-parity bit. The SRAM itself is outside the block. The wrapper drives its address, write enable, write data and write parity, and it takes back the read word and its parity bits one cycle after a read.

A full-word write goes straight to the array in one cycle and recomputes all four parity bits. It neither reads nor checks the word it replaces. A read, or a write that enables only some byte lanes, first fetches the stored word. When the checking enable is high, the wrapper compares the parity of every lane of that word. On a clean read the data are returned. On a clean sub-word write the new lanes are merged into the fetched word, and the word is written back with fresh parity. A mismatch ends the access with an error response in place of the data. A sub-word write that finds a mismatch is dropped. When the checking enable is low, no error is ever reported. A sub-word write in that mode still merges the lanes and rewrites parity for the whole word.

The bus master holds select, direction, address, strobes and write data steady until it sees ready high, and it drops select or changes the request after that cycle.

Top module: `par_sram_bank`

## Requirements
- R1: A write with all four byte strobes set completes in the cycle it is presented. Ready is high in that cycle, and the array is written at the given word with the bus data. No read is issued for it.
- R2: A read keeps ready low in its first cycle and issues an array read in that cycle. In the second cycle it raises ready and returns the stored word on the read data.
- R3: Every array write carries four parity bits, where bit i is set exactly when byte i (data bits 8i+7..8i) holds an odd number of ones. Each lane together with its bit therefore has even parity.
- R4: With checking enabled, a read of a word whose stored parity disagrees with its data in any lane raises the error output together with ready.
- R5: With checking disabled, the error output stays low on reads and sub-word writes even when the stored parity is wrong. In that case a sub-word write still completes and stores correct parity for the whole merged word.
- R6: A write with some but not all byte strobes set takes two cycles. In the first, ready is low and the stored word is read. In the second, ready is high and the word is written back. Lanes whose strobe (bit i for byte i) is set take the new data, and the other lanes keep their stored data.
- R7: With checking enabled, a sub-word write that finds a parity mismatch in the stored word raises the error with ready and performs no array write.
- R8: A full-word write never raises the error, even over a stored word with bad parity. Afterwards the word reads back clean with checking enabled.
- R9: The error output is only ever high together with ready, and it is high for exactly one cycle per faulting access.
- R10: The word address selects one of 2048 words (index 0 to 2047) and is passed unchanged to the array address.
- R11: After reset, with no request presented, ready, error and the array write enable are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_en | input | 1 | Parity checking enable for this bank |
| bus_sel | input | 1 | Access request, held until ready |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 11 | Word address within the bank |
| bus_be | input | 4 | Byte strobes, bit i enables byte i |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not returning a clean read |
| bus_ready | output | 1 | Access completes this cycle |
| bus_err | output | 1 | Error response, valid with ready |
| mem_en | output | 1 | Array access enable |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 11 | Array word address |
| mem_wdata | output | 32 | Array write data |
| mem_wpar | output | 4 | Array write parity, one bit per byte |
| mem_rdata | input | 32 | Array read data, one cycle after a read |
| mem_rpar | input | 4 | Array read parity, one cycle after a read |

## Verification
The main path is driven with full-word writes, single-byte writes, two-byte writes and reads, at the lowest and highest word. These patterns separate the one-cycle direct write from the two-cycle fetch-and-merge path, and they show whether the merge keeps exactly the lanes that have no strobe. Parity is corrupted in the external array model, and the same word is then read and partially written with checking on and off. This tells the reporting of a fault apart from the suppression of the write and from the enable gating. A full-word write over a corrupted word confirms that this path skips the check and repairs the parity.

// File: rtl/par_sram_pkg.sv
package par_sram_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_CHECK = 1'b1
  } bank_st_e;

  // even-parity bit for one byte lane: set when the byte has an odd count of ones
  function automatic logic byte_even_par(input logic [7:0] b);
    return ^b;
  endfunction

  // one lane after a merge: new byte when its strobe is set, stored byte otherwise
  function automatic logic [7:0] lane_merge(input logic [7:0] old_b,
                                            input logic [7:0] new_b,
                                            input logic       strobe);
    return strobe ? new_b : old_b;
  endfunction

endpackage

// File: rtl/par_gen.sv
module par_gen
  import par_sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0] data,
  output logic [LANES-1:0]   par
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign par[i] = byte_even_par(data[8*i +: 8]);
  end
endmodule

// File: rtl/par_chk.sv
module par_chk
  import par_sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0] data,
  input  logic [LANES-1:0]   par,
  output logic [LANES-1:0]   bad_lanes
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign bad_lanes[i] = byte_even_par(data[8*i +: 8]) ^ par[i];
  end
endmodule

// File: rtl/rmw_merge.sv
module rmw_merge
  import par_sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0] old_word,
  input  logic [8*LANES-1:0] new_word,
  input  logic [LANES-1:0]   strobes,
  output logic [8*LANES-1:0] merged
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign merged[8*i +: 8] = lane_merge(old_word[8*i +: 8], new_word[8*i +: 8], strobes[i]);
  end
endmodule

// File: rtl/par_sram_bank.sv
module par_sram_bank
  import par_sram_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int ADDR_W = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 chk_en,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_waddr,
  input  logic [LANES-1:0]     bus_be,
  input  logic [8*LANES-1:0]   bus_wdata,
  output logic [8*LANES-1:0]   bus_rdata,
  output logic                 bus_ready,
  output logic                 bus_err,
  output logic                 mem_en,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [8*LANES-1:0]   mem_wdata,
  output logic [LANES-1:0]     mem_wpar,
  input  logic [8*LANES-1:0]   mem_rdata,
  input  logic [LANES-1:0]     mem_rpar
);
  localparam int DATA_W = 8 * LANES;

  bank_st_e state_q, state_d;

  // named internal events, also seen by the checker
  logic              in_idle;
  logic              in_chk;
  logic              req_full_wr;
  logic              start_fetch;
  logic              parity_fault;
  logic              commit_sub;
  logic              commit_full;
  logic [LANES-1:0]  bad_lanes;
  logic [DATA_W-1:0] merged_word;

  assign in_idle      = (state_q == ST_IDLE);
  assign in_chk       = (state_q == ST_CHECK);
  assign req_full_wr  = bus_sel && bus_wr && (&bus_be);
  assign start_fetch  = in_idle && bus_sel && !req_full_wr;
  assign commit_full  = in_idle && req_full_wr;

  par_chk #(.LANES(LANES)) u_chk_par (
    .data      (mem_rdata),
    .par       (mem_rpar),
    .bad_lanes (bad_lanes)
  );

  rmw_merge #(.LANES(LANES)) u_merge (
    .old_word (mem_rdata),
    .new_word (bus_wdata),
    .strobes  (bus_be),
    .merged   (merged_word)
  );

  assign parity_fault = in_chk && chk_en && (|bad_lanes);
  assign commit_sub   = in_chk && bus_wr && !parity_fault;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_fetch) state_d = ST_CHECK;
      ST_CHECK: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign mem_en    = (in_idle && bus_sel) || commit_sub;
  assign mem_we    = commit_full || commit_sub;
  assign mem_addr  = bus_waddr;
  assign mem_wdata = in_chk ? merged_word : bus_wdata;

  par_gen #(.LANES(LANES)) u_gen_par (
    .data (mem_wdata),
    .par  (mem_wpar)
  );

  assign bus_ready = commit_full || in_chk;
  assign bus_err   = parity_fault;
  assign bus_rdata = (in_chk && !bus_wr && !parity_fault) ? mem_rdata : '0;

endmodule

// File: rtl/par_sram_bank_chk.sv
module par_sram_bank_chk #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic               chk_en,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [LANES-1:0]   bus_be,
  input logic               bus_ready,
  input logic               bus_err,
  input logic               mem_en,
  input logic               mem_we,
  input logic [8*LANES-1:0] mem_wdata,
  input logic [LANES-1:0]   mem_wpar,
  input logic               in_chk
);

  p_full_write_direct_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && (&bus_be) && !in_chk) |-> (bus_ready && mem_we && !bus_err));

  p_second_cycle_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_chk |-> bus_ready);

  p_fetch_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !in_chk && !(bus_wr && (&bus_be))) |-> (!bus_ready && mem_en && !mem_we) ##1 in_chk);

  for (genvar i = 0; i < LANES; i++) begin : g_par
    p_lane_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ($countones({mem_wdata[8*i +: 8], mem_wpar[i]}) % 2 == 0));
  end

  p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |-> !bus_err);

  p_err_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> !mem_we);

  p_err_with_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_ready);

  p_err_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> !bus_err);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_sel && !in_chk) |-> (!bus_ready && !bus_err && !mem_we));

endmodule

bind par_sram_bank par_sram_bank_chk #(.LANES(LANES), .ADDR_W(ADDR_W)) u_bank_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chk_en    (chk_en),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_be    (bus_be),
  .bus_ready (bus_ready),
  .bus_err   (bus_err),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .mem_wpar  (mem_wpar),
  .in_chk    (in_chk)
);

// File: tb/par_sram_bank_bench.sv
module par_sram_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 2048;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        chk_en;
  logic        bus_sel, bus_wr;
  logic [10:0] bus_waddr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_ready, bus_err;
  logic        mem_en, mem_we;
  logic [10:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0]  mem_wpar, mem_rpar;

  int tests = 0;
  int fails = 0;
  int wr_pulses = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  par_sram_bank u_par_sram_bank (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_waddr(bus_waddr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_err(bus_err),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wpar(mem_wpar), .mem_rdata(mem_rdata), .mem_rpar(mem_rpar)
  );

  // external synchronous SRAM model
  logic [31:0] mdat [WORDS];
  logic [3:0]  mpar [WORDS];
  initial begin
    for (int i = 0; i < WORDS; i++) begin mdat[i] = '0; mpar[i] = '0; end
    mem_rdata = '0; mem_rpar = '0;
  end
  always @(posedge clk) begin
    if (mem_en && mem_we) begin
      mdat[mem_addr] <= mem_wdata;
      mpar[mem_addr] <= mem_wpar;
      wr_pulses <= wr_pulses + 1;
    end else if (mem_en) begin
      mem_rdata <= mdat[mem_addr];
      mem_rpar  <= mpar[mem_addr];
    end
  end

  function automatic logic [3:0] exp_par(input logic [31:0] w);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = ($countones(w[8*i +: 8]) % 2) == 1;
    return p;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, expv);
    end
  endtask

  task automatic access(input logic wr, input logic [10:0] a, input logic [3:0] be,
                        input logic [31:0] wd, output logic [31:0] rd, output logic er,
                        output int cyc);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_waddr = a; bus_be = be; bus_wdata = wd;
    cyc = 1;
    #1;
    while (!bus_ready && cyc < 8) begin
      @(negedge clk); #1; cyc++;
    end
    rd = bus_rdata; er = bus_err;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  typedef struct packed {
    logic        wr;
    logic [10:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] rd;
    logic [1:0]  cyc;
  } vec_t;

  localparam vec_t TBL [9] = '{
    '{1'b1, 11'd0,    4'hF, 32'h11223344, 32'h0,        2'd1},
    '{1'b0, 11'd0,    4'h0, 32'h0,        32'h11223344, 2'd2},
    '{1'b1, 11'd0,    4'h2, 32'hAAAAAAAA, 32'h0,        2'd2},
    '{1'b0, 11'd0,    4'h0, 32'h0,        32'h1122AA44, 2'd2},
    '{1'b1, 11'd2047, 4'hF, 32'hDEADBEEF, 32'h0,        2'd1},
    '{1'b1, 11'd2047, 4'hC, 32'h5A5A0000, 32'h0,        2'd2},
    '{1'b0, 11'd2047, 4'h0, 32'h0,        32'h5A5ABEEF, 2'd2},
    '{1'b1, 11'd1,    4'h3, 32'h1234CAFE, 32'h0,        2'd2},
    '{1'b0, 11'd1,    4'h0, 32'h0,        32'h0000CAFE, 2'd2}
  };

  initial begin
    #(CLK_PERIOD * 200000);
    tests++; fails++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        er;
    int          cyc;
    int          wp;
    rst_n = 1'b0; chk_en = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_waddr = '0; bus_be = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R11 quiet after reset
    check(!bus_ready && !bus_err && !mem_we, "R11 idle outputs", {29'd0, bus_ready, bus_err, mem_we}, 32'h0);

    // table of basic accesses, checking enabled, clean array
    foreach (TBL[k]) begin
      access(TBL[k].wr, TBL[k].addr, TBL[k].be, TBL[k].wd, rd, er, cyc);
      check(cyc == int'(TBL[k].cyc), TBL[k].wr ? ((&TBL[k].be) ? "R1 full write cycles" : "R6 sub write cycles")
                                                 : "R2 read cycles", cyc, TBL[k].cyc);
      check(!er, "R8/R4 clean access no error", {31'd0, er}, 32'h0);
      if (!TBL[k].wr) check(rd == TBL[k].rd, "R2 R6 read data", rd, TBL[k].rd);
    end
    // R10 top word lands at array index 2047; R3 stored parity
    check(mdat[2047] == 32'h5A5ABEEF, "R10 top word in array", mdat[2047], 32'h5A5ABEEF);
    check(mpar[2047] == exp_par(32'h5A5ABEEF), "R3 parity top word", {28'd0, mpar[2047]}, {28'd0, exp_par(32'h5A5ABEEF)});
    check(mpar[0] == exp_par(32'h1122AA44), "R3 parity word 0", {28'd0, mpar[0]}, {28'd0, exp_par(32'h1122AA44)});

    // R4 corrupted lane 0 of word 0, checked read
    @(negedge clk); mpar[0] = mpar[0] ^ 4'h1;
    access(1'b0, 11'd0, 4'h0, 32'h0, rd, er, cyc);
    check(er == 1'b1, "R4 read error flagged", {31'd0, er}, 32'h1);
    check(cyc == 2, "R9 error comes with ready", cyc, 2);
    #1;
    check(!bus_err, "R9 error single cycle", {31'd0, bus_err}, 32'h0);

    // R5 same word, checking disabled: no error, data returned
    chk_en = 1'b0;
    access(1'b0, 11'd0, 4'h0, 32'h0, rd, er, cyc);
    check(!er, "R5 read no error when disabled", {31'd0, er}, 32'h0);
    check(rd == 32'h1122AA44, "R5 read data when disabled", rd, 32'h1122AA44);

    // R7 checked sub-word write over bad word: error, no array write
    chk_en = 1'b1;
    wp = wr_pulses;
    access(1'b1, 11'd0, 4'h1, 32'h000000FF, rd, er, cyc);
    check(er == 1'b1, "R7 sub write error", {31'd0, er}, 32'h1);
    @(negedge clk);
    check(wr_pulses == wp, "R7 no array write", wr_pulses, wp);
    check(mdat[0] == 32'h1122AA44, "R7 word unchanged", mdat[0], 32'h1122AA44);

    // R5 unchecked sub-word write repairs parity
    chk_en = 1'b0;
    access(1'b1, 11'd0, 4'h1, 32'h00000077, rd, er, cyc);
    check(!er, "R5 sub write no error when disabled", {31'd0, er}, 32'h0);
    chk_en = 1'b1;
    access(1'b0, 11'd0, 4'h0, 32'h0, rd, er, cyc);
    check(!er && rd == 32'h1122AA77, "R5 R6 merged word clean", rd, 32'h1122AA77);

    // R8 full write over corrupted word: direct, no error, repaired
    @(negedge clk); mpar[1] = mpar[1] ^ 4'h8;
    access(1'b1, 11'd1, 4'hF, 32'hCAFEF00D, rd, er, cyc);
    check(!er && cyc == 1, "R8 full write over bad word", {31'd0, er}, 32'h0);
    access(1'b0, 11'd1, 4'h0, 32'h0, rd, er, cyc);
    check(!er && rd == 32'hCAFEF00D, "R8 readback clean", rd, 32'hCAFEF00D);

    // R6 halfword upper lanes over fresh word
    access(1'b1, 11'd5, 4'hC, 32'hBEEF1111, rd, er, cyc);
    check(mdat[5] == 32'hBEEF0000, "R6 upper half merge", mdat[5], 32'hBEEF0000);
    check(mpar[5] == exp_par(32'hBEEF0000), "R3 parity merged word", {28'd0, mpar[5]}, {28'd0, exp_par(32'hBEEF0000)});

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule